// File: doc/BRIEF.md
# Local Bus Master Cycle Engine

This block runs bus-master cycles on a 32-bit local bus of the 486 family. An internal DMA-side requester hands it one request at a time: direction, memory or I/O space, data or control, a word address and a beat count of one to four. The engine drives the address strobe, the cycle-definition outputs, the byte enables and the burst-last strobe. It moves the write data out or captures the read data, and it follows the target's two ready inputs until the request is complete. A burst covers one aligned 16-byte line. The word address steps by one for each beat.

A target that answers a burst beat with the plain ready input ends the bus cycle there. The engine then finishes the rest of the request as separate single cycles, and each of these starts with its own address strobe. When the engine is not bus master, it watches the address strobe from other masters. It raises a one-cycle hit for any I/O access whose upper address bits match a programmed base, and it reports the word offset, the byte enables and the direction of that access.

Top module: `lbm_engine`

## Requirements
- R1: After reset, `lbAdsN` and `lbBlastN` are high, `lbAddrOe`, `lbDatOe`, `slvHit`, `rdValid` and `xferDone` are low, and `reqReady` equals `isMaster`.
- R2: A request is taken on a clock where `reqValid` and `reqReady` are both high. In the next clock `lbAdsN` is low for exactly one clock, with `lbAddrOut`, `lbMioOut` (1 = memory, 0 = I/O), `lbDcOut` and `lbWrOut` showing the request. `lbAdsN` goes low only while `isMaster` is high.
- R3: Byte enables are active low, and bit 3 enables data bits 31..24, bit 2 bits 23..16, bit 1 bits 15..8 and bit 0 bits 7..0. A one-beat request drives `reqBeN` on `lbBeNOut`. A request of two or more beats drives all four lanes enabled (4'b0000).
- R4: In a burst, `lbBrdyN` sampled low accepts the current beat without a new address strobe, and `lbAddrOut` rises by one word for the next beat. `lbBlastN` is low only during the data phase of the final beat.
- R5: A one-beat cycle holds `lbBlastN` low in its data phase, and either ready input sampled low ends it.
- R6: `lbRdyN` sampled low on a beat while `lbBlastN` is high ends the bus cycle. Each remaining beat is then issued as its own single cycle, with its own address strobe and `lbBlastN` low.
- R7: When both ready inputs are sampled low on the same clock, the cycle ends as it does for `lbRdyN` alone.
- R8: Read data is captured from `lbDatIn` on the clock edge where a ready input is sampled low. `rdValid` is high for one clock after that edge, with the word on `rdData`.
- R9: `wrTake` is high once for each write beat, on the clock where `wrData` is latched. `lbDatOut` holds that word, with `lbDatOe` high, from the address phase until the beat's ready is sampled.
- R10: While both ready inputs stay high in a data phase, the engine stays in that data phase with address, strobes and data unchanged.
- R11: `xferDone` is high for one clock after the edge that completes the final beat, and the address outputs are then released (`lbAddrOe` low).
- R12: When `isMaster` is low and the engine is idle, an address strobe `lbAdsNIn` low with `lbMioIn` low and `lbAddrIn[29:3]` equal to `slvBase` sets `slvHit` high for one clock after that edge. `slvOffset` then shows `lbAddrIn[2:0]`, `slvWrite` shows `lbWrIn` and `slvBeN` shows `lbBeNIn`.
- R13: No slave hit is raised when `lbMioIn` is high, when the base does not match, or when `isMaster` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| isMaster | input | 1 | Bus ownership granted by the external arbiter |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqData | input | 1 | 1 = data cycle, 0 = control cycle |
| reqAddr | input | 30 | Word address (byte address bits 31..2) |
| reqBeats | input | 3 | Beat count, 1 to 4 |
| reqBeN | input | 4 | Active-low byte enables for a one-beat request |
| wrData | input | 32 | Write word for the next beat |
| wrTake | output | 1 | `wrData` is latched on this clock |
| rdValid | output | 1 | Read word valid on `rdData` |
| rdData | output | 32 | Captured read word |
| xferDone | output | 1 | Request completed |
| lbAddrOut | output | 30 | Bus address driven as master |
| lbAddrOe | output | 1 | Address and cycle-definition outputs enabled |
| lbAdsN | output | 1 | Address strobe, active low |
| lbMioOut | output | 1 | Memory/I/O cycle definition |
| lbDcOut | output | 1 | Data/control cycle definition |
| lbWrOut | output | 1 | Write/read cycle definition |
| lbBeNOut | output | 4 | Active-low byte enables as master |
| lbBlastN | output | 1 | Burst-last, active low |
| lbDatOut | output | 32 | Write data driven on the bus |
| lbDatOe | output | 1 | Data output enable |
| lbRdyN | input | 1 | Plain ready return, active low |
| lbBrdyN | input | 1 | Burst ready, active low |
| lbDatIn | input | 32 | Read data from the bus |
| lbAddrIn | input | 30 | Bus address seen as slave |
| lbAdsNIn | input | 1 | Address strobe from another master |
| lbMioIn | input | 1 | Memory/I/O seen as slave |
| lbWrIn | input | 1 | Write/read seen as slave |
| lbBeNIn | input | 4 | Byte enables seen as slave |
| slvBase | input | 27 | Programmed I/O base, compared with address bits 29..3 |
| slvHit | output | 1 | One-cycle slave match pulse |
| slvOffset | output | 3 | Word offset of the matched access |
| slvWrite | output | 1 | Direction of the matched access |
| slvBeN | output | 4 | Byte enables of the matched access |

## Verification
The properties assume that the arbiter keeps `isMaster` high from the accepted request until `xferDone`, and that the target drives its ready inputs low only in a data phase, never on an address-strobe clock. They also assume that another master's address strobe lasts a single clock. The bench acts as a target that follows all of these rules. It drives the ready inputs only after it has seen the address phase, and it drives the foreign strobe only while `isMaster` is low. It keeps every burst inside one line by starting at offset zero with at most four beats.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA
  } lbm_state_e;

  // Strobes from control to datapath, one clock each.
  typedef struct packed {
    logic load;       // take a new request
    logic advance;    // step to the next beat
    logic latchWr;    // capture wrData into the hold lanes
    logic captureRd;  // capture lbDatIn as a read beat
  } lbm_strobe_t;

endpackage

// File: rtl/lbm_ctrl.sv
module lbm_ctrl
  import lbm_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic              lastBeat,
  input  logic              curWrite,
  input  logic              rdyN,
  input  logic              brdyN,
  output logic              reqReady,
  output logic              adsActive,
  output logic              busy,
  output logic              blastActive,
  output logic              slvEnable,
  output logic              xferDone,
  output lbm_strobe_t       stb
);

  lbm_state_e stateQ, stateD;
  logic       singleQ, singleD;
  logic       accept, inData, rdyHit, brdyHit, beatDone, cycleEnd;

  always_comb begin
    accept      = (stateQ == ST_IDLE) && isMaster && reqValid;
    inData      = (stateQ == ST_DATA);
    rdyHit      = inData && !rdyN;
    brdyHit     = inData && !brdyN;
    beatDone    = rdyHit || brdyHit;
    blastActive = inData && (singleQ || lastBeat);
    // plain ready always closes the bus cycle; burst ready only with burst-last
    cycleEnd    = rdyHit || blastActive;
  end

  always_comb begin
    stateD  = stateQ;
    singleD = singleQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          stateD  = ST_ADDR;
          singleD = (reqBeats <= BEAT_W'(1));
        end
      end
      ST_ADDR: stateD = ST_DATA;
      ST_DATA: begin
        if (beatDone) begin
          if (rdyHit) singleD = 1'b1;
          if (lastBeat)      stateD = ST_IDLE;
          else if (cycleEnd) stateD = ST_ADDR;
          else               stateD = ST_DATA;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      singleQ  <= 1'b0;
      xferDone <= 1'b0;
    end else begin
      stateQ   <= stateD;
      singleQ  <= singleD;
      xferDone <= beatDone && lastBeat;
    end
  end

  always_comb begin
    reqReady      = (stateQ == ST_IDLE) && isMaster;
    adsActive     = (stateQ == ST_ADDR);
    busy          = (stateQ != ST_IDLE);
    slvEnable     = (stateQ == ST_IDLE) && !isMaster;
    stb.load      = accept;
    stb.advance   = beatDone && !lastBeat;
    stb.latchWr   = (accept && reqWrite) || (beatDone && !lastBeat && curWrite);
    stb.captureRd = beatDone && !curWrite;
  end

endmodule

// File: rtl/lbm_dpath.sv
module lbm_dpath
  import lbm_pkg::*;
#(
  parameter int ADDR_W    = 30,
  parameter int DATA_W    = 32,
  parameter int BEAT_W    = 3,
  parameter int SLV_OFS_W = 3,
  localparam int LANES    = DATA_W / 8,
  localparam int BASE_W   = ADDR_W - SLV_OFS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lbm_strobe_t          stb,
  input  logic                 slvEnable,
  input  logic                 reqWrite,
  input  logic                 reqMem,
  input  logic                 reqData,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [BEAT_W-1:0]    reqBeats,
  input  logic [LANES-1:0]     reqBeN,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    lbDatIn,
  input  logic [ADDR_W-1:0]    lbAddrIn,
  input  logic                 lbAdsNIn,
  input  logic                 lbMioIn,
  input  logic                 lbWrIn,
  input  logic [LANES-1:0]     lbBeNIn,
  input  logic [BASE_W-1:0]    slvBase,
  output logic                 lastBeat,
  output logic                 curWrite,
  output logic [ADDR_W-1:0]    addrQ,
  output logic                 mioQ,
  output logic                 dcQ,
  output logic [LANES-1:0]     beNQ,
  output logic [DATA_W-1:0]    wrHold,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic                 slvHit,
  output logic [SLV_OFS_W-1:0] slvOffset,
  output logic                 slvWrite,
  output logic [LANES-1:0]     slvBeN
);

  logic [BEAT_W-1:0] remQ;
  logic              writeQ;
  logic              slvMatch;

  assign lastBeat = (remQ == BEAT_W'(1));
  assign curWrite = writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      remQ   <= '0;
      writeQ <= 1'b0;
      mioQ   <= 1'b0;
      dcQ    <= 1'b0;
      beNQ   <= '1;
    end else if (stb.load) begin
      addrQ  <= reqAddr;
      remQ   <= (reqBeats == '0) ? BEAT_W'(1) : reqBeats;
      writeQ <= reqWrite;
      mioQ   <= reqMem;
      dcQ    <= reqData;
      beNQ   <= (reqBeats <= BEAT_W'(1)) ? reqBeN : '0;
    end else if (stb.advance) begin
      addrQ  <= addrQ + 1'b1;
      remQ   <= remQ - 1'b1;
    end
  end

  // Write data hold, one register per byte lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            wrHold[g*8 +: 8] <= '0;
      else if (stb.latchWr) wrHold[g*8 +: 8] <= wrData[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.captureRd;
      if (stb.captureRd) rdData <= lbDatIn;
    end
  end

  // I/O slave decode on a foreign address strobe.
  assign slvMatch = slvEnable && !lbAdsNIn && !lbMioIn &&
                    (lbAddrIn[ADDR_W-1:SLV_OFS_W] == slvBase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slvHit    <= 1'b0;
      slvOffset <= '0;
      slvWrite  <= 1'b0;
      slvBeN    <= '1;
    end else begin
      slvHit <= slvMatch;
      if (slvMatch) begin
        slvOffset <= lbAddrIn[SLV_OFS_W-1:0];
        slvWrite  <= lbWrIn;
        slvBeN    <= lbBeNIn;
      end
    end
  end

endmodule

// File: rtl/lbm_engine.sv
module lbm_engine
  import lbm_pkg::*;
#(
  parameter int ADDR_W    = 30,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4,
  parameter int SLV_OFS_W = 3,
  localparam int LANES    = DATA_W / 8,
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1),
  localparam int BASE_W   = ADDR_W - SLV_OFS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 isMaster,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic                 reqMem,
  input  logic                 reqData,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [BEAT_W-1:0]    reqBeats,
  input  logic [LANES-1:0]     reqBeN,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 wrTake,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic                 xferDone,
  output logic [ADDR_W-1:0]    lbAddrOut,
  output logic                 lbAddrOe,
  output logic                 lbAdsN,
  output logic                 lbMioOut,
  output logic                 lbDcOut,
  output logic                 lbWrOut,
  output logic [LANES-1:0]     lbBeNOut,
  output logic                 lbBlastN,
  output logic [DATA_W-1:0]    lbDatOut,
  output logic                 lbDatOe,
  input  logic                 lbRdyN,
  input  logic                 lbBrdyN,
  input  logic [DATA_W-1:0]    lbDatIn,
  input  logic [ADDR_W-1:0]    lbAddrIn,
  input  logic                 lbAdsNIn,
  input  logic                 lbMioIn,
  input  logic                 lbWrIn,
  input  logic [LANES-1:0]     lbBeNIn,
  input  logic [BASE_W-1:0]    slvBase,
  output logic                 slvHit,
  output logic [SLV_OFS_W-1:0] slvOffset,
  output logic                 slvWrite,
  output logic [LANES-1:0]     slvBeN
);

  lbm_strobe_t stb;
  logic        lastBeat, curWrite, adsActive, busy, blastActive, slvEnable;

  lbm_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .isMaster    (isMaster),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqBeats    (reqBeats),
    .lastBeat    (lastBeat),
    .curWrite    (curWrite),
    .rdyN        (lbRdyN),
    .brdyN       (lbBrdyN),
    .reqReady    (reqReady),
    .adsActive   (adsActive),
    .busy        (busy),
    .blastActive (blastActive),
    .slvEnable   (slvEnable),
    .xferDone    (xferDone),
    .stb         (stb)
  );

  lbm_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BEAT_W    (BEAT_W),
    .SLV_OFS_W (SLV_OFS_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .slvEnable (slvEnable),
    .reqWrite  (reqWrite),
    .reqMem    (reqMem),
    .reqData   (reqData),
    .reqAddr   (reqAddr),
    .reqBeats  (reqBeats),
    .reqBeN    (reqBeN),
    .wrData    (wrData),
    .lbDatIn   (lbDatIn),
    .lbAddrIn  (lbAddrIn),
    .lbAdsNIn  (lbAdsNIn),
    .lbMioIn   (lbMioIn),
    .lbWrIn    (lbWrIn),
    .lbBeNIn   (lbBeNIn),
    .slvBase   (slvBase),
    .lastBeat  (lastBeat),
    .curWrite  (curWrite),
    .addrQ     (lbAddrOut),
    .mioQ      (lbMioOut),
    .dcQ       (lbDcOut),
    .beNQ      (lbBeNOut),
    .wrHold    (lbDatOut),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .slvHit    (slvHit),
    .slvOffset (slvOffset),
    .slvWrite  (slvWrite),
    .slvBeN    (slvBeN)
  );

  assign wrTake   = stb.latchWr;
  assign lbAddrOe = busy;
  assign lbAdsN   = !adsActive;
  assign lbBlastN = !blastActive;
  assign lbWrOut  = curWrite;
  assign lbDatOe  = busy && curWrite;

endmodule

// File: rtl/lbm_engine_chk.sv
module lbm_engine_chk #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              isMaster,
  input logic              lbAdsN,
  input logic              lbAddrOe,
  input logic [ADDR_W-1:0] lbAddrOut,
  input logic              lbBlastN,
  input logic [LANES-1:0]  lbBeNOut,
  input logic              lbRdyN,
  input logic              lbBrdyN,
  input logic              lbDatOe,
  input logic [DATA_W-1:0] lbDatOut,
  input logic              lbAdsNIn,
  input logic              lbMioIn,
  input logic              slvHit,
  input logic              xferDone
);

  a_r2_ads_when_master: assert property (@(posedge clk) disable iff (!rstN)
    !lbAdsN |-> (isMaster && lbAddrOe));

  a_r2_ads_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    !lbAdsN |=> lbAdsN);

  a_r3_burst_all_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (lbAddrOe && lbAdsN && lbBlastN) |-> (lbBeNOut == '0));

  a_r4_burst_step: assert property (@(posedge clk) disable iff (!rstN)
    (lbAddrOe && lbAdsN && lbBlastN && !lbBrdyN && lbRdyN)
      |=> (lbAdsN && lbAddrOut == $past(lbAddrOut) + 1'b1));

  // R5, R6 and R7: a closing ready leaves the data phase
  a_r6_cycle_closes: assert property (@(posedge clk) disable iff (!rstN)
    (lbAddrOe && lbAdsN && (!lbRdyN || (!lbBlastN && !lbBrdyN)))
      |=> (!lbAddrOe || !lbAdsN));

  a_r9_wdata_held: assert property (@(posedge clk) disable iff (!rstN)
    (lbDatOe && (!lbAdsN || (lbRdyN && lbBrdyN))) |=> $stable(lbDatOut));

  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lbAddrOe && lbAdsN && lbRdyN && lbBrdyN)
      |=> (lbAddrOe && lbAdsN && $stable(lbAddrOut) && $stable(lbBlastN)));

  a_r11_done_released: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !lbAddrOe);

  a_r12_hit_cause: assert property (@(posedge clk) disable iff (!rstN)
    slvHit |-> $past(!lbAdsNIn && !lbMioIn && !isMaster));

endmodule

bind lbm_engine lbm_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lbm_engine_tb.sv
module lbm_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isMaster = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqMem = 1'b1;
  logic        reqData = 1'b1;
  logic [29:0] reqAddr = '0;
  logic [2:0]  reqBeats = 3'd1;
  logic [3:0]  reqBeN = 4'hF;
  logic [31:0] wrData;
  logic        wrTake;
  logic        rdValid;
  logic [31:0] rdData;
  logic        xferDone;
  logic [29:0] lbAddrOut;
  logic        lbAddrOe, lbAdsN, lbMioOut, lbDcOut, lbWrOut;
  logic [3:0]  lbBeNOut;
  logic        lbBlastN;
  logic [31:0] lbDatOut;
  logic        lbDatOe;
  logic        lbRdyN = 1'b1;
  logic        lbBrdyN = 1'b1;
  logic [31:0] lbDatIn = '0;
  logic [29:0] lbAddrIn = '0;
  logic        lbAdsNIn = 1'b1;
  logic        lbMioIn = 1'b1;
  logic        lbWrIn = 1'b0;
  logic [3:0]  lbBeNIn = 4'hF;
  logic [26:0] slvBase = 27'h2A5_1C3;
  logic        slvHit;
  logic [2:0]  slvOffset;
  logic        slvWrite;
  logic [3:0]  slvBeN;

  int checks = 0;
  int errors = 0;
  int takeIdx = 0;
  bit finished = 1'b0;

  always #10 clk = !clk;

  always @(posedge clk) if (wrTake) takeIdx <= takeIdx + 1;
  function automatic logic [31:0] wordOf(int idx);
    return 32'h5A00_0000 + 32'(idx) * 32'h0001_0203;
  endfunction
  assign wrData = wordOf(takeIdx);

  lbm_engine u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runXfer(input bit wr, input int beats, input int mode, input int waits, input int iter);
    logic [29:0] base;
    logic [3:0]  be;
    int          take0;
    bit          fallen;
    base = 30'h0100_0000 + 30'(iter * 4);
    be   = 4'(iter * 5 + 1);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqMem = iter[0]; reqData = !iter[1];
    reqAddr = base; reqBeats = 3'(beats); reqBeN = be;
    take0 = takeIdx;
    @(negedge clk);
    reqValid = 1'b0;
    fallen = 1'b0;
    for (int k = 0; k < beats; k++) begin
      bit useRdy, useBrdy, blastExp;
      useRdy  = (mode == 2) || ((mode == 1 || mode == 3) && k == 0) || (mode == 4 && k == 1);
      useBrdy = !useRdy || (mode == 3 && k == 0);
      blastExp = (beats == 1) || fallen || (k == beats - 1);
      if (k == 0 || fallen) begin
        chk(!lbAdsN && lbAddrOut == base + 30'(k), (k == 0) ? "R2 strobe" : "R6 restrobe",
            {lbAdsN, 2'b0, lbAddrOut}, {3'b0, base + 30'(k)});
        chk(lbMioOut == reqMem && lbDcOut == reqData && lbWrOut == wr, "R2 cycle def",
            {lbMioOut, lbDcOut, lbWrOut}, {reqMem, reqData, wr});
        @(negedge clk);
      end
      for (int w = 0; w < waits; w++) begin
        chk(lbAdsN && lbAddrOe && lbBlastN == !blastExp, "R10 wait",
            {lbAdsN, lbAddrOe, lbBlastN}, {2'b11, !blastExp});
        @(negedge clk);
      end
      chk(lbAdsN && lbAddrOut == base + 30'(k), "R4 beat address", lbAddrOut, base + 30'(k));
      chk(lbBlastN == !blastExp, (beats == 1) ? "R5 blast" : (fallen ? "R6 blast" : "R4 blast"),
          lbBlastN, !blastExp);
      chk(lbBeNOut == ((beats == 1) ? be : 4'h0), "R3 lanes", lbBeNOut, (beats == 1) ? be : 4'h0);
      if (wr) chk(lbDatOe && lbDatOut == wordOf(take0 + k), "R9 write data", lbDatOut, wordOf(take0 + k));
      else    chk(!lbDatOe, "R9 read no drive", lbDatOe, 0);
      lbRdyN = !useRdy; lbBrdyN = !useBrdy;
      lbDatIn = 32'hC300_0000 ^ 32'(iter * 16 + k);
      @(negedge clk);
      lbRdyN = 1'b1; lbBrdyN = 1'b1;
      if (!wr) chk(rdValid && rdData == (32'hC300_0000 ^ 32'(iter * 16 + k)), "R8 read capture",
                   rdData, 32'hC300_0000 ^ 32'(iter * 16 + k));
      if (useRdy) fallen = 1'b1;
      if (mode == 3 && k == 0 && beats > 1)
        chk(!lbAdsN, "R7 both readies close", lbAdsN, 0);
    end
    chk(xferDone && !lbAddrOe && lbAdsN, "R11 done", {xferDone, lbAddrOe}, 2'b10);
    chk((takeIdx - take0) == (wr ? beats : 0), "R9 take count", takeIdx - take0, wr ? beats : 0);
    @(negedge clk);
    chk(!xferDone, "R11 done pulse", xferDone, 0);
  endtask

  task automatic slvProbe(input bit master, input logic [26:0] hi, input bit mio,
                          input int ofs, input bit wr, input bit expHit, input string tag);
    logic [3:0] be;
    be = 4'(ofs ^ 4'h9);
    @(negedge clk);
    isMaster = master;
    lbAdsNIn = 1'b0; lbAddrIn = {hi, 3'(ofs)}; lbMioIn = mio; lbWrIn = wr; lbBeNIn = be;
    @(negedge clk);
    lbAdsNIn = 1'b1;
    chk(slvHit == expHit, tag, slvHit, expHit);
    if (expHit)
      chk(slvOffset == 3'(ofs) && slvWrite == wr && slvBeN == be, "R12 fields",
          {slvOffset, slvWrite, slvBeN}, {3'(ofs), wr, be});
    @(negedge clk);
    chk(!slvHit, "R12 pulse width", slvHit, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int iter;
    repeat (3) @(negedge clk);
    chk(lbAdsN && lbBlastN && !lbAddrOe && !lbDatOe && !slvHit && !rdValid && !xferDone,
        "R1 reset outputs", {lbAdsN, lbBlastN, lbAddrOe, lbDatOe, slvHit}, 5'b11000);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == isMaster, "R1 ready follows master", reqReady, isMaster);
    iter = 0;
    for (int beats = 1; beats <= 4; beats++)
      for (int wr = 0; wr < 2; wr++)
        for (int mode = 0; mode < 5; mode++)
          for (int waits = 0; waits < 3; waits++) begin
            runXfer(wr[0], beats, mode, waits, iter);
            iter++;
          end
    // slave decode sweep
    for (int ofs = 0; ofs < 8; ofs++)
      for (int wr = 0; wr < 2; wr++) begin
        slvProbe(1'b0, slvBase, 1'b0, ofs, wr[0], 1'b1, "R12 hit");
        slvProbe(1'b0, slvBase, 1'b1, ofs, wr[0], 1'b0, "R13 memory ignored");
        slvProbe(1'b0, slvBase ^ 27'(1 << ofs), 1'b0, ofs, wr[0], 1'b0, "R13 base mismatch");
        slvProbe(1'b1, slvBase, 1'b0, ofs, wr[0], 1'b0, "R13 master ignores");
      end
    isMaster = 1'b0;
    @(negedge clk);
    chk(!reqReady, "R1 no ready without grant", reqReady, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule